// File: doc/BRIEF.md
# Lockable Two-Way Data Cache

This block is a 16 KB read cache with two ways and 256 sets of 32-byte lines. The caller presents a set index and beat select taken from the virtual address. In the same cycle it presents the physical tag that the address translation unit produced, together with that tag's parity bit. One cycle later the block answers with a hit or a miss and, on a hit, 8 bytes of data. Every stored byte carries its own parity bit and every stored tag carries one. A parity mismatch is flagged, and the lookup counts as a miss on the way concerned.

On a miss the block stops taking lookups. It raises a line-fill request carrying the line address, waits for the grant, and then takes four 8-byte beats in ascending order. The line becomes valid only when the last beat has been written, and lookups resume on the next cycle. The requester re-issues the lookup after the fill.

A lock input pins way 0. Once a line sits in way 0, later refills in that set go to way 1, so critical data stays resident. The only exception is a line in way 0 that fails its parity check, which is replaced to repair it. The control is a three-state machine. `ST_IDLE` accepts lookups and moves to `ST_REQ` when a lookup misses. `ST_REQ` drives the fill request and moves to `ST_FILL` on the grant. `ST_FILL` collects the beats and returns to `ST_IDLE` on the fourth beat.

Top module: `lockway_dcache`

## Requirements
- R1: The set index is virtual address bits [12:5] and the beat select is bits [4:3]. Both arrive on `lk_vidx`, which carries address bits [12:3]. The tag on `lk_ptag` is physical address bits [35:13]. `fill_addr` is {tag, index}.
- R2: A lookup is accepted on a clock edge where `lk_valid` and `lk_ready` are both high. In the following cycle `rd_valid` is high, and exactly one of `rd_hit` or `rd_miss` is high. Without an accepted lookup, `rd_valid` is low.
- R3: On a hit, `rd_data` returns the 8 bytes stored for the selected beat of the line, with byte k on bits [8k+7:8k]. When the lookup does not hit, `rd_data` is zero.
- R4: After a miss, `fill_req` is high from the next cycle with `fill_addr` = {tag, index}. Both hold until `fill_grant` is sampled high. `lk_ready` stays low from the miss cycle until the fill ends.
- R5: In the fill phase, `fill_beat_rdy` is high. Beats are taken when `fill_beat_valid` and `fill_beat_rdy` are both high, and they land at line offsets 0, 8, 16 and 24 in that order. The line turns valid only on the fourth beat. In the cycle after that beat, `fill_beat_rdy` is low and `lk_ready` is high.
- R6: Refill victim choice without errors or lock: an invalid way first, way 0 before way 1. Otherwise the least recently used way, where a hit or a fill marks a way as recently used.
- R7: With `lock_en` high, a valid and error-free line in way 0 is never the victim; refills go to way 1. An empty way 0 is still filled first, and that line then stays.
- R8: Beat parity arrives on `fill_beat_par` and is stored as given. Parity bit k must equal the XOR of byte k. A mismatch on the selected beat of a way whose tag matches sets `rd_data_perr`, and that way does not hit.
- R9: The tag parity bit `lk_tpar` of a missing lookup is stored with the line. It must equal the XOR of the stored tag. Any valid way that breaks this rule sets `rd_tag_perr` and cannot hit.
- R10: If a way has a parity error in a lookup that misses, the lowest such way is the refill victim, even when it is locked.
- R11: After reset all lines are invalid. `lk_ready` is high, and `rd_valid`, `fill_req` and `fill_beat_rdy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_en | input | 1 | Pin way 0 against replacement |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_vidx | input | 10 | Virtual address bits [12:3] |
| lk_ptag | input | 23 | Physical tag, address bits [35:13] |
| lk_tpar | input | 1 | Parity of `lk_ptag` |
| rd_valid | output | 1 | Lookup result present |
| rd_hit | output | 1 | Lookup hit |
| rd_miss | output | 1 | Lookup missed |
| rd_data | output | 64 | Read data of the selected beat |
| rd_tag_perr | output | 1 | Stored tag parity error in the set |
| rd_data_perr | output | 1 | Byte parity error on the selected beat |
| fill_req | output | 1 | Line fill request |
| fill_grant | input | 1 | Fill request accepted |
| fill_addr | output | 31 | Line address {tag, index} |
| fill_beat_valid | input | 1 | Fill beat present |
| fill_beat_rdy | output | 1 | Fill beat can be taken |
| fill_beat_data | input | 64 | Fill beat data |
| fill_beat_par | input | 8 | Per-byte parity of the fill beat |

## Verification
The hardest states to reach are a stored line whose tag or byte parity is bad, and the same fault inside a locked way. The ports only ever write parity that the outside supplies. The bench reaches these states by giving a wrong `lk_tpar` on a lookup that misses, or by flipping one bit of `fill_beat_par` on a chosen beat. It then looks up the same line again and expects the error flag, a miss and a refill into the damaged way. Random traffic confined to a few sets and tags, with `lock_en` toggled in phases, mixes these faults with LRU and lock victim choices.

// File: rtl/lwc_pkg.sv
package lwc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_FILL
    } lwc_state_e;

    // The way that lock_en protects
    localparam logic LOCK_WAY = 1'b0;
endpackage

// File: rtl/lwc_tag_store.sv
module lwc_tag_store #(
    parameter  int SETS  = 256,
    parameter  int TAG_W = 23,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [1:0]            rd_vld,
    output logic [1:0][TAG_W-1:0] rd_tag,
    output logic [1:0]            rd_tpar,
    input  logic [IDX_W-1:0]      lru_idx,
    output logic                  lru_way,
    input  logic                  touch_en,
    input  logic [IDX_W-1:0]      touch_idx,
    input  logic                  touch_way,
    input  logic                  inv_en,
    input  logic [IDX_W-1:0]      inv_idx,
    input  logic                  inv_way,
    input  logic                  set_en,
    input  logic [IDX_W-1:0]      set_idx,
    input  logic                  set_way,
    input  logic [TAG_W-1:0]      set_tag,
    input  logic                  set_tpar
);
    // One bit per set naming the least recently used way
    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (touch_en) begin
            lru_q[touch_idx] <= ~touch_way;
        end
    end

    assign lru_way = lru_q[lru_idx];

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [SETS-1:0] vld_q;
        logic [TAG_W:0]  tmem [SETS];
        logic [TAG_W:0]  entry_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q     <= '0;
                rd_vld[w] <= 1'b0;
            end else begin
                if (inv_en && inv_way == 1'(w)) begin
                    vld_q[inv_idx] <= 1'b0;
                end else if (set_en && set_way == 1'(w)) begin
                    vld_q[set_idx] <= 1'b1;
                end
                if (rd_en) begin
                    rd_vld[w] <= vld_q[rd_idx];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (set_en && set_way == 1'(w)) begin
                tmem[set_idx] <= {set_tpar, set_tag};
            end
            if (rd_en) begin
                entry_q <= tmem[rd_idx];
            end
        end

        assign rd_tag[w]  = entry_q[TAG_W-1:0];
        assign rd_tpar[w] = entry_q[TAG_W];
    end
endmodule

// File: rtl/lwc_data_store.sv
module lwc_data_store #(
    parameter  int SETS       = 256,
    parameter  int BEATS      = 4,
    parameter  int BEAT_BYTES = 8,
    localparam int ADDR_W     = $clog2(SETS * BEATS),
    localparam int DW         = BEAT_BYTES * 8
) (
    input  logic                       clk,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [1:0][DW-1:0]         rd_data,
    output logic [1:0][BEAT_BYTES-1:0] rd_par,
    input  logic                       wr_en,
    input  logic                       wr_way,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DW-1:0]              wr_data,
    input  logic [BEAT_BYTES-1:0]      wr_par
);
    localparam int DEPTH = SETS * BEATS;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [DW+BEAT_BYTES-1:0] mem [DEPTH];
        logic [DW+BEAT_BYTES-1:0] word_q;

        always_ff @(posedge clk) begin
            if (wr_en && wr_way == 1'(w)) begin
                mem[wr_addr] <= {wr_par, wr_data};
            end
            if (rd_en) begin
                word_q <= mem[rd_addr];
            end
        end

        assign rd_data[w] = word_q[DW-1:0];
        assign rd_par[w]  = word_q[DW+BEAT_BYTES-1:DW];
    end
endmodule

// File: rtl/lwc_way_judge.sv
module lwc_way_judge #(
    parameter  int TAG_W      = 23,
    parameter  int BEAT_BYTES = 8,
    localparam int DW         = BEAT_BYTES * 8
) (
    input  logic [1:0]                 vld,
    input  logic [1:0][TAG_W-1:0]      tag,
    input  logic [1:0]                 tpar,
    input  logic [1:0][DW-1:0]         data,
    input  logic [1:0][BEAT_BYTES-1:0] dpar,
    input  logic [TAG_W-1:0]           look_tag,
    input  logic                       lru_way,
    input  logic                       lock_en,
    output logic                       hit,
    output logic                       hit_way,
    output logic [DW-1:0]              hit_data,
    output logic                       tag_perr,
    output logic                       data_perr,
    output logic                       victim
);
    logic [1:0] tag_eq, tpar_bad, dpar_bad, way_hit, suspect, dperr_w;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [BEAT_BYTES-1:0] calc;
        for (genvar b = 0; b < BEAT_BYTES; b++) begin : g_byte
            assign calc[b] = ^data[w][8*b +: 8];
        end
        assign tag_eq[w]   = (tag[w] == look_tag);
        assign tpar_bad[w] = (^tag[w]) != tpar[w];
        assign dpar_bad[w] = |(calc ^ dpar[w]);
        assign dperr_w[w]  = vld[w] && !tpar_bad[w] && tag_eq[w] && dpar_bad[w];
        assign way_hit[w]  = vld[w] && tag_eq[w] && !tpar_bad[w] && !dpar_bad[w];
        assign suspect[w]  = (vld[w] && tpar_bad[w]) || dperr_w[w];
    end

    assign hit       = |way_hit;
    assign hit_way   = !way_hit[0];
    assign hit_data  = way_hit[0] ? data[0] : (way_hit[1] ? data[1] : '0);
    assign tag_perr  = |(vld & tpar_bad);
    assign data_perr = |dperr_w;

    always_comb begin
        if (suspect[0]) begin
            victim = 1'b0;
        end else if (suspect[1]) begin
            victim = 1'b1;
        end else if (!vld[0]) begin
            victim = 1'b0;
        end else if (!vld[1]) begin
            victim = 1'b1;
        end else if (lock_en) begin
            victim = ~lwc_pkg::LOCK_WAY;
        end else begin
            victim = lru_way;
        end
    end
endmodule

// File: rtl/lockway_dcache.sv
module lockway_dcache
    import lwc_pkg::*;
#(
    parameter  int PA_W        = 36,
    parameter  int SETS        = 256,
    parameter  int LINE_BYTES  = 32,
    parameter  int BEAT_BYTES  = 8,
    localparam int IDX_W       = $clog2(SETS),
    localparam int OFF_W       = $clog2(LINE_BYTES),
    localparam int BEATS       = LINE_BYTES / BEAT_BYTES,
    localparam int BEAT_W      = $clog2(BEATS),
    localparam int TAG_W       = PA_W - IDX_W - OFF_W,
    localparam int DW          = BEAT_BYTES * 8,
    localparam int LINE_ADDR_W = PA_W - OFF_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lock_en,
    input  logic                   lk_valid,
    output logic                   lk_ready,
    input  logic [IDX_W+BEAT_W-1:0] lk_vidx,
    input  logic [TAG_W-1:0]       lk_ptag,
    input  logic                   lk_tpar,
    output logic                   rd_valid,
    output logic                   rd_hit,
    output logic                   rd_miss,
    output logic [DW-1:0]          rd_data,
    output logic                   rd_tag_perr,
    output logic                   rd_data_perr,
    output logic                   fill_req,
    input  logic                   fill_grant,
    output logic [LINE_ADDR_W-1:0] fill_addr,
    input  logic                   fill_beat_valid,
    output logic                   fill_beat_rdy,
    input  logic [DW-1:0]          fill_beat_data,
    input  logic [BEAT_BYTES-1:0]  fill_beat_par
);
    lwc_state_e state_q, state_d;

    // Lookup stage registers
    logic                 pv_q;
    logic [IDX_W-1:0]     p_idx_q;
    logic [TAG_W-1:0]     p_tag_q;
    logic                 p_tpar_q;

    // Fill context
    logic [IDX_W-1:0]     f_idx_q;
    logic [TAG_W-1:0]     f_tag_q;
    logic                 f_tpar_q;
    logic                 f_way_q;
    logic [BEAT_W-1:0]    f_cnt_q;

    // Store and judge wiring
    logic [1:0]                 t_vld;
    logic [1:0][TAG_W-1:0]      t_tag;
    logic [1:0]                 t_tpar;
    logic                       t_lru;
    logic [1:0][DW-1:0]         d_data;
    logic [1:0][BEAT_BYTES-1:0] d_par;
    logic                       j_hit, j_hit_way, j_tag_perr, j_data_perr, j_victim;
    logic [DW-1:0]              j_data;

    logic accept, miss_now, beat_acc, last_beat, start_fill;

    assign accept     = lk_valid && lk_ready;
    assign miss_now   = pv_q && !j_hit;
    assign start_fill = (state_q == ST_IDLE) && miss_now;
    assign beat_acc   = fill_beat_valid && fill_beat_rdy;
    assign last_beat  = beat_acc && (f_cnt_q == BEAT_W'(BEATS - 1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (miss_now)   state_d = ST_REQ;
            ST_REQ:  if (fill_grant) state_d = ST_FILL;
            ST_FILL: if (last_beat)  state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pv_q     <= 1'b0;
            p_idx_q  <= '0;
            p_tag_q  <= '0;
            p_tpar_q <= 1'b0;
            f_idx_q  <= '0;
            f_tag_q  <= '0;
            f_tpar_q <= 1'b0;
            f_way_q  <= 1'b0;
            f_cnt_q  <= '0;
        end else begin
            pv_q <= accept;
            if (accept) begin
                p_idx_q  <= lk_vidx[IDX_W+BEAT_W-1:BEAT_W];
                p_tag_q  <= lk_ptag;
                p_tpar_q <= lk_tpar;
            end
            if (start_fill) begin
                f_idx_q  <= p_idx_q;
                f_tag_q  <= p_tag_q;
                f_tpar_q <= p_tpar_q;
                f_way_q  <= j_victim;
            end
            if (state_q == ST_REQ && fill_grant) begin
                f_cnt_q <= '0;
            end else if (beat_acc) begin
                f_cnt_q <= f_cnt_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        lk_ready      = (state_q == ST_IDLE) && !miss_now;
        rd_valid      = pv_q;
        rd_hit        = pv_q && j_hit;
        rd_miss       = miss_now;
        rd_data       = (pv_q && j_hit) ? j_data : '0;
        rd_tag_perr   = pv_q && j_tag_perr;
        rd_data_perr  = pv_q && j_data_perr;
        fill_req      = (state_q == ST_REQ);
        fill_beat_rdy = (state_q == ST_FILL);
        fill_addr     = {f_tag_q, f_idx_q};
    end

    lwc_tag_store #(
        .SETS  (SETS),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (accept),
        .rd_idx    (lk_vidx[IDX_W+BEAT_W-1:BEAT_W]),
        .rd_vld    (t_vld),
        .rd_tag    (t_tag),
        .rd_tpar   (t_tpar),
        .lru_idx   (p_idx_q),
        .lru_way   (t_lru),
        .touch_en  ((pv_q && j_hit) || last_beat),
        .touch_idx (last_beat ? f_idx_q : p_idx_q),
        .touch_way (last_beat ? f_way_q : j_hit_way),
        .inv_en    (start_fill),
        .inv_idx   (p_idx_q),
        .inv_way   (j_victim),
        .set_en    (last_beat),
        .set_idx   (f_idx_q),
        .set_way   (f_way_q),
        .set_tag   (f_tag_q),
        .set_tpar  (f_tpar_q)
    );

    lwc_data_store #(
        .SETS       (SETS),
        .BEATS      (BEATS),
        .BEAT_BYTES (BEAT_BYTES)
    ) u_data (
        .clk     (clk),
        .rd_en   (accept),
        .rd_addr (lk_vidx),
        .rd_data (d_data),
        .rd_par  (d_par),
        .wr_en   (beat_acc),
        .wr_way  (f_way_q),
        .wr_addr ({f_idx_q, f_cnt_q}),
        .wr_data (fill_beat_data),
        .wr_par  (fill_beat_par)
    );

    lwc_way_judge #(
        .TAG_W      (TAG_W),
        .BEAT_BYTES (BEAT_BYTES)
    ) u_judge (
        .vld       (t_vld),
        .tag       (t_tag),
        .tpar      (t_tpar),
        .data      (d_data),
        .dpar      (d_par),
        .look_tag  (p_tag_q),
        .lru_way   (t_lru),
        .lock_en   (lock_en),
        .hit       (j_hit),
        .hit_way   (j_hit_way),
        .hit_data  (j_data),
        .tag_perr  (j_tag_perr),
        .data_perr (j_data_perr),
        .victim    (j_victim)
    );
endmodule

// File: rtl/lockway_dcache_sva.sv
module lockway_dcache_sva #(
    parameter int LINE_ADDR_W = 31,
    parameter int BEATS       = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lk_valid,
    input logic                   lk_ready,
    input logic                   rd_valid,
    input logic                   rd_hit,
    input logic                   rd_miss,
    input logic                   fill_req,
    input logic                   fill_grant,
    input logic [LINE_ADDR_W-1:0] fill_addr,
    input logic                   fill_beat_valid,
    input logic                   fill_beat_rdy
);
    logic [3:0] beats_q;
    logic       beat_acc;

    assign beat_acc = fill_beat_valid && fill_beat_rdy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats_q <= '0;
        end else if (fill_req) begin
            beats_q <= '0;
        end else if (beat_acc) begin
            beats_q <= beats_q + 1'b1;
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_hit != rd_miss));                                  // R2
    AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> rd_valid);                               // R2
    AST_MISS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_miss |=> fill_req);                                              // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_grant) |=> (fill_req && $stable(fill_addr)));   // R4
    AST_BLOCK_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req || fill_beat_rdy) |-> !lk_ready);                         // R4
    AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_beat_rdy |-> (beats_q < 4'(BEATS)));                           // R5
    AST_LINE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_acc && beats_q == 4'(BEATS - 1)) |=> (!fill_beat_rdy && lk_ready)); // R5
endmodule

bind lockway_dcache lockway_dcache_sva #(
    .LINE_ADDR_W (LINE_ADDR_W),
    .BEATS       (BEATS)
) u_sva (
    .clk             (clk),
    .rst_n           (rst_n),
    .lk_valid        (lk_valid),
    .lk_ready        (lk_ready),
    .rd_valid        (rd_valid),
    .rd_hit          (rd_hit),
    .rd_miss         (rd_miss),
    .fill_req        (fill_req),
    .fill_grant      (fill_grant),
    .fill_addr       (fill_addr),
    .fill_beat_valid (fill_beat_valid),
    .fill_beat_rdy   (fill_beat_rdy)
);

// File: tb/lockway_dcache_test.sv
module lockway_dcache_test;
    localparam int TAG_W = 23;
    localparam int SETS  = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_en = 1'b0;
    logic        lk_valid = 1'b0;
    logic        lk_ready;
    logic [9:0]  lk_vidx = '0;
    logic [22:0] lk_ptag = '0;
    logic        lk_tpar = 1'b0;
    logic        rd_valid, rd_hit, rd_miss, rd_tag_perr, rd_data_perr;
    logic [63:0] rd_data;
    logic        fill_req;
    logic        fill_grant = 1'b0;
    logic [30:0] fill_addr;
    logic        fill_beat_valid = 1'b0;
    logic        fill_beat_rdy;
    logic [63:0] fill_beat_data = '0;
    logic [7:0]  fill_beat_par = '0;

    always #4 clk = ~clk;

    lockway_dcache uut (
        .clk(clk), .rst_n(rst_n), .lock_en(lock_en),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vidx(lk_vidx),
        .lk_ptag(lk_ptag), .lk_tpar(lk_tpar),
        .rd_valid(rd_valid), .rd_hit(rd_hit), .rd_miss(rd_miss),
        .rd_data(rd_data), .rd_tag_perr(rd_tag_perr), .rd_data_perr(rd_data_perr),
        .fill_req(fill_req), .fill_grant(fill_grant), .fill_addr(fill_addr),
        .fill_beat_valid(fill_beat_valid), .fill_beat_rdy(fill_beat_rdy),
        .fill_beat_data(fill_beat_data), .fill_beat_par(fill_beat_par)
    );

    // Reference model of the tag side
    logic             m_vld  [2][SETS];
    logic [TAG_W-1:0] m_tag  [2][SETS];
    logic             m_tpok [2][SETS];
    logic [3:0]       m_dbad [2][SETS];
    logic             m_lru  [SETS];

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    function automatic logic [63:0] memfn(logic [22:0] t, logic [7:0] s, logic [1:0] b);
        return {t, s, b, ~t, s};
    endfunction

    function automatic logic [7:0] bpar(logic [63:0] d);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = ^d[8*i +: 8];
        return r;
    endfunction

    // One lookup; on a predicted miss the line is refilled.
    // bad_beat >= 0 corrupts the parity of that beat during the fill.
    task automatic lookup(input string req, input logic [7:0] s, input logic [1:0] b,
                          input logic [22:0] t, input bit bad_tpar, input int bad_beat);
        logic [1:0] hw, susp;
        logic       exp_hit, exp_tperr, exp_dperr, vic;
        @(negedge clk);
        chk(req, "lk_ready before lookup", 64'(lk_ready), 64'd1);
        lk_valid = 1'b1;
        lk_vidx  = {s, b};
        lk_ptag  = t;
        lk_tpar  = (^t) ^ bad_tpar;
        @(negedge clk);
        lk_valid = 1'b0;
        exp_tperr = 1'b0;
        exp_dperr = 1'b0;
        for (int w = 0; w < 2; w++) begin
            logic eq, tbad, dbad;
            eq   = m_tag[w][s] == t;
            tbad = m_vld[w][s] && !m_tpok[w][s];
            dbad = m_vld[w][s] && m_tpok[w][s] && eq && m_dbad[w][s][b];
            hw[w]   = m_vld[w][s] && m_tpok[w][s] && eq && !m_dbad[w][s][b];
            susp[w] = tbad || dbad;
            exp_tperr |= tbad;
            exp_dperr |= dbad;
        end
        exp_hit = |hw;
        chk(req, "rd_valid", 64'(rd_valid), 64'd1);
        chk(req, "rd_hit", 64'(rd_hit), 64'(exp_hit));
        chk(req, "rd_miss", 64'(rd_miss), 64'(!exp_hit));
        chk(req, "rd_data", rd_data, exp_hit ? memfn(t, s, b) : 64'd0);
        chk(req, "rd_tag_perr (R9)", 64'(rd_tag_perr), 64'(exp_tperr));
        chk(req, "rd_data_perr (R8)", 64'(rd_data_perr), 64'(exp_dperr));
        if (exp_hit) begin
            m_lru[s] = hw[0] ? 1'b1 : 1'b0;
        end else begin
            if (susp[0])             vic = 1'b0;
            else if (susp[1])        vic = 1'b1;
            else if (!m_vld[0][s])   vic = 1'b0;
            else if (!m_vld[1][s])   vic = 1'b1;
            else if (lock_en)        vic = 1'b1;
            else                     vic = m_lru[s];
            @(negedge clk);
            chk("R4", "fill_req", 64'(fill_req), 64'd1);
            chk("R4", "fill_addr", 64'(fill_addr), 64'({t, s}));
            chk("R4", "lk_ready in request", 64'(lk_ready), 64'd0);
            repeat ($urandom_range(0, 2)) begin
                @(negedge clk);
                chk("R4", "fill_req held", 64'(fill_req), 64'd1);
            end
            fill_grant = 1'b1;
            @(negedge clk);
            fill_grant = 1'b0;
            for (int k = 0; k < 4; k++) begin
                repeat ($urandom_range(0, 1)) @(negedge clk);
                chk("R5", "beat ready", 64'(fill_beat_rdy), 64'd1);
                fill_beat_valid = 1'b1;
                fill_beat_data  = memfn(t, s, 2'(k));
                fill_beat_par   = bpar(fill_beat_data) ^ ((k == bad_beat) ? 8'h10 : 8'h00);
                @(negedge clk);
                fill_beat_valid = 1'b0;
                if (k < 3) chk("R5", "lk_ready during fill", 64'(lk_ready), 64'd0);
            end
            chk("R5", "lk_ready after line", 64'(lk_ready), 64'd1);
            chk("R5", "beat ready after line", 64'(fill_beat_rdy), 64'd0);
            m_vld[vic][s]  = 1'b1;
            m_tag[vic][s]  = t;
            m_tpok[vic][s] = !bad_tpar;
            m_dbad[vic][s] = (bad_beat >= 0) ? 4'(1 << bad_beat) : 4'd0;
            m_lru[s]       = ~vic;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        for (int s = 0; s < SETS; s++) begin
            m_lru[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin
                m_vld[w][s] = 1'b0; m_tag[w][s] = '0; m_tpok[w][s] = 1'b1; m_dbad[w][s] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "lk_ready", 64'(lk_ready), 64'd1);
        chk("R11", "rd_valid", 64'(rd_valid), 64'd0);
        chk("R11", "fill_req", 64'(fill_req), 64'd0);
        chk("R11", "fill_beat_rdy", 64'(fill_beat_rdy), 64'd0);

        // R1/R3/R5: cold miss, then every beat of the line hits
        lookup("R1", 8'd5, 2'd2, 23'h12345, 0, -1);
        for (int b = 0; b < 4; b++) lookup("R3", 8'd5, 2'(b), 23'h12345, 0, -1);
        // R6: second tag goes to the empty way, then LRU replacement
        lookup("R6", 8'd5, 2'd0, 23'h00ABC, 0, -1);
        lookup("R6", 8'd5, 2'd1, 23'h12345, 0, -1);
        lookup("R6", 8'd5, 2'd1, 23'h7FFFF, 0, -1);
        lookup("R6", 8'd5, 2'd3, 23'h12345, 0, -1);
        lookup("R6", 8'd5, 2'd3, 23'h00ABC, 0, -1);
        // R7: locked way 0 survives repeated conflicts
        lock_en = 1'b1;
        lookup("R7", 8'd9, 2'd0, 23'h00111, 0, -1);
        lookup("R7", 8'd9, 2'd0, 23'h00222, 0, -1);
        lookup("R7", 8'd9, 2'd0, 23'h00222, 0, -1);
        lookup("R7", 8'd9, 2'd0, 23'h00333, 0, -1);
        lookup("R7", 8'd9, 2'd0, 23'h00444, 0, -1);
        lookup("R7", 8'd9, 2'd1, 23'h00111, 0, -1);
        lock_en = 1'b0;
        // R9/R10: bad tag parity stored, detected, repaired
        lookup("R9", 8'd20, 2'd0, 23'h04040, 1, -1);
        lookup("R9", 8'd20, 2'd0, 23'h04040, 0, -1);
        lookup("R10", 8'd20, 2'd0, 23'h04040, 0, -1);
        // R8/R10: bad byte parity on beat 2 only
        lookup("R8", 8'd30, 2'd0, 23'h05050, 0, 2);
        lookup("R8", 8'd30, 2'd0, 23'h05050, 0, -1);
        lookup("R8", 8'd30, 2'd2, 23'h05050, 0, -1);
        lookup("R10", 8'd30, 2'd2, 23'h05050, 0, -1);
        // R10: parity error inside the locked way forces its replacement
        lock_en = 1'b1;
        lookup("R10", 8'd40, 2'd0, 23'h06060, 1, -1);
        lookup("R10", 8'd40, 2'd0, 23'h07070, 0, -1);
        lookup("R10", 8'd40, 2'd0, 23'h08080, 0, -1);
        lookup("R10", 8'd40, 2'd0, 23'h07070, 0, -1);
        lock_en = 1'b0;

        // Random traffic in a few crowded sets
        for (int i = 0; i < 600; i++) begin
            logic [7:0]  s;
            logic [22:0] t;
            if (i % 50 == 0) lock_en = ~lock_en;
            s = 8'(100 + $urandom_range(0, 3));
            t = 23'($urandom_range(0, 4));
            lookup("R6", s, 2'($urandom_range(0, 3)), t,
                   ($urandom_range(0, 11) == 0),
                   ($urandom_range(0, 11) == 0) ? int'($urandom_range(0, 3)) : -1);
        end

        summary();
        $finish;
    end
endmodule